// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

The block is a free-running up-counter with four compare channels, set up through a small register bus. The bus has an address, a write strobe, write data and read data. Reads are combinational and writes take effect on the rising clock edge. The counter advances by one on each cycle in which the count strobe `tick_i` is high, so the tick rate is set by whatever drives that strobe. Software can load the counter with a new value at any time.

A match event happens on the clock edge where a tick moves the counter onto a channel's compare value. If that channel's interrupt enable bit is set, its sticky status bit is set and its interrupt line rises. Software clears a status bit by writing a one to it. Channel 3 can also act as a watchdog. When the watchdog arm bit is set, a channel 3 match raises a one-cycle system reset request and disarms the watchdog.

Register offsets are byte addresses, and all registers are 32 bits wide:

| Offset | Register |
|---|---|
| 0x00, 0x04, 0x08, 0x0C | compare values for channels 0 to 3 |
| 0x10 | counter |
| 0x14 | status |
| 0x18 | watchdog arm |
| 0x1C | interrupt enable |

Top module: `ostimer_wdt`

## Requirements
- R1: After reset, the counter, all four compare values, status, interrupt enable and watchdog arm all read 0, and `irq_o` and `rst_req_o` are low.
- R2: A write to offset 0x10 loads the counter with the write data on that edge, even when `tick_i` is high in the same cycle. A read of 0x10 returns the current count.
- R3: On each edge where `tick_i` is high and the counter is not being written, the counter increases by one, wrapping from 0xFFFFFFFF to 0. Without a tick, it holds its value.
- R4: The compare value of channel n is read and written in full at offset 4*n, for n from 0 to 3.
- R5: When a tick moves the counter onto the compare value of channel n and interrupt enable bit n is set, status bit n and `irq_o[n]` go high on that same edge. Loading the counter directly onto a compare value is not a match.
- R6: A match on a channel whose interrupt enable bit is clear leaves its status bit and interrupt line unchanged.
- R7: A write to the status register (0x14) clears exactly the status bits written as 1, and the matching `irq_o` lines fall. Bits written as 0 are kept. Status bit n sits at bit n, and the unused upper bits read 0.
- R8: With watchdog arm bit 0 (offset 0x18) set, a channel 3 match drives `rst_req_o` high for exactly one cycle, starting after that edge. The arm register then reads 0. This happens whatever interrupt enable bit 3 holds.
- R9: While the watchdog arm bit is 0, a channel 3 match never asserts `rst_req_o`.
- R10: The interrupt enable register (0x1C) stores bits 11:0 of the write data. Bits 31:12 read 0.
- R11: A read of any offset outside the map, including an unaligned one, returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count strobe: the counter advances on edges where this is high |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 4 | Interrupt line per channel, equal to its status bit |
| rst_req_o | output | 1 | One-cycle system reset request from the watchdog |

## Verification
A wrong count shows up in the counter read at once. It also moves every match event, so an interrupt or reset request rises on the wrong edge or not at all. This can be seen within the few ticks of each directed sequence.

A status bit that does not stick, or does not clear, is visible on `irq_o` in the cycle after the faulty edge. A watchdog that fails to disarm is caught by counting reset pulses over a second pass through the compare value.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
   localparam int OFS_COUNT  = 'h10;
   localparam int OFS_STATUS = 'h14;
   localparam int OFS_WDOG   = 'h18;
   localparam int OFS_IEN    = 'h1C;

   function automatic int ofs_match(input int ch);
      return ch * 4;
   endfunction
endpackage

// File: rtl/ostm_counter.sv
module ostm_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] cnt_o,
   output logic         adv_o,
   output logic [W-1:0] nxt_o
);
   logic [W-1:0] cnt_q;

   assign adv_o = tick_i && !ld_i;
   assign nxt_o = cnt_q + W'(1);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld_i)  cnt_q <= ld_val_i;
      else if (adv_o) cnt_q <= nxt_o;
   end

   assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_i) |=> cnt_q == $past(cnt_q) + W'(1));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ld_i) |=> $stable(cnt_q));
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> cnt_q == $past(ld_val_i));
endmodule

// File: rtl/ostm_match_bank.sv
module ostm_match_bank #(
   parameter int W   = 32,
   parameter int NCH = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv_i,
   input  logic [W-1:0]            nxt_i,
   input  logic [NCH-1:0]          mwr_i,
   input  logic [W-1:0]            wdata_i,
   input  logic [NCH-1:0]          ien_i,
   input  logic                    clr_wr_i,
   output logic [NCH-1:0][W-1:0]   match_o,
   output logic [NCH-1:0]          evt_o,
   output logic [NCH-1:0]          sts_o
);
   logic [NCH-1:0][W-1:0] cmp_q;
   logic [NCH-1:0]        sts_q;
   logic [NCH-1:0]        clr_mask;

   assign clr_mask = clr_wr_i ? wdata_i[NCH-1:0] : '0;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cmp_q[n] <= '0;
         else if (mwr_i[n]) cmp_q[n] <= wdata_i;
      end

      assign evt_o[n] = adv_i && (nxt_i == cmp_q[n]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_q[n] <= 1'b0;
         else        sts_q[n] <= (sts_q[n] && !clr_mask[n]) || (evt_o[n] && ien_i[n]);
      end

      assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_o[n] && ien_i[n]) |=> sts_q[n]);
      assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!ien_i[n] && !sts_q[n]) |=> !sts_q[n]);
      assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_q[n] && !(clr_wr_i && wdata_i[n])) |=> sts_q[n]);
   end

   assign match_o = cmp_q;
   assign sts_o   = sts_q;
endmodule

// File: rtl/ostm_wdog.sv
module ostm_wdog (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic wr_i,
   input  logic arm_i,
   output logic arm_o,
   output logic rst_req_o
);
   logic arm_q, req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         req_q <= 1'b0;
      end else if (evt_i && arm_q) begin
         arm_q <= 1'b0;
         req_q <= 1'b1;
      end else begin
         req_q <= 1'b0;
         if (wr_i) arm_q <= arm_i;
      end
   end

   assign arm_o     = arm_q;
   assign rst_req_o = req_q;

   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);
   assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> !arm_q);
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q |=> !req_q);
endmodule

// File: rtl/ostimer_wdt.sv
module ostimer_wdt #(
   parameter int W      = 32,
   parameter int NCH    = 4,
   parameter int IEN_W  = 12,
   parameter int ADDR_W = 8,
   parameter int WDT_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [W-1:0]      wdata_i,
   output logic [W-1:0]      rdata_o,
   output logic [NCH-1:0]    irq_o,
   output logic              rst_req_o
);
   import ostm_pkg::*;

   if (NCH < 1 || ofs_match(NCH) > OFS_COUNT) begin : g_bad_nch
      $error("NCH must fit below the counter offset");
   end
   if (WDT_CH < 0 || WDT_CH >= NCH) begin : g_bad_wdt
      $error("WDT_CH must name an existing channel");
   end
   if (IEN_W < NCH || IEN_W > W) begin : g_bad_ien
      $error("IEN_W must cover all channels and fit the data width");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_WDOG   = ADDR_W'(OFS_WDOG);
   localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);

   logic [W-1:0]          cnt_w, nxt_w;
   logic                  adv_w;
   logic [NCH-1:0]        mwr_w, evt_w, sts_w;
   logic [NCH-1:0][W-1:0] match_w;
   logic [IEN_W-1:0]      ien_q;
   logic                  arm_w;

   for (genvar n = 0; n < NCH; n++) begin : g_mwr
      assign mwr_w[n] = wr_i && (addr_i == ADDR_W'(ofs_match(n)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ien_q <= '0;
      else if (wr_i && addr_i == A_IEN) ien_q <= wdata_i[IEN_W-1:0];
   end

   ostm_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .ld_i(wr_i && addr_i == A_COUNT), .ld_val_i(wdata_i),
      .cnt_o(cnt_w), .adv_o(adv_w), .nxt_o(nxt_w)
   );

   ostm_match_bank #(.W(W), .NCH(NCH)) u_bank (
      .clk(clk), .rst_n(rst_n), .adv_i(adv_w), .nxt_i(nxt_w),
      .mwr_i(mwr_w), .wdata_i(wdata_i), .ien_i(ien_q[NCH-1:0]),
      .clr_wr_i(wr_i && addr_i == A_STATUS),
      .match_o(match_w), .evt_o(evt_w), .sts_o(sts_w)
   );

   ostm_wdog u_wdog (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_w[WDT_CH]),
      .wr_i(wr_i && addr_i == A_WDOG), .arm_i(wdata_i[0]),
      .arm_o(arm_w), .rst_req_o(rst_req_o)
   );

   always_comb begin
      rdata_o = '0;
      for (int n = 0; n < NCH; n++) begin
         if (addr_i == ADDR_W'(ofs_match(n))) rdata_o = match_w[n];
      end
      if (addr_i == A_COUNT)  rdata_o = cnt_w;
      if (addr_i == A_STATUS) rdata_o = W'(sts_w);
      if (addr_i == A_WDOG)   rdata_o = W'(arm_w);
      if (addr_i == A_IEN)    rdata_o = W'(ien_q);
   end

   assign irq_o = sts_w;

   assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_STATUS && !(|evt_w)) |=> ((irq_o & $past(wdata_i[NCH-1:0])) == '0));
endmodule

// File: tb/sim_ostimer_wdt.sv
module sim_ostimer_wdt;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic        wr_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic [3:0]  irq_o;
   logic        rst_req_o;

   int n_total = 0;
   int n_pass  = 0;
   int rst_pulses = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ostimer_wdt u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
      .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   always @(negedge clk) if (rst_n && rst_req_o) rst_pulses++;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_total++;
      if (got === exp) n_pass++;
      else $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      addr_i = a;
      #1 v = rdata_o;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 'h20; a += 4) begin
         rd(a[7:0], v);
         check("R1 register reads zero after reset", v, 32'h0);
      end
      check("R1 irq low", {28'h0, irq_o}, 32'h0);
      check("R1 rst_req low", {31'h0, rst_req_o}, 32'h0);
   endtask

   task automatic t_load();
      logic [31:0] v;
      wr('h10, 32'h1234_5678);
      rd('h10, v);
      check("R2 counter load", v, 32'h1234_5678);
      @(negedge clk);
      addr_i = 'h10; wdata_i = 32'h0000_0500; wr_i = 1'b1; tick_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0; tick_i = 1'b0;
      rd('h10, v);
      check("R2 load wins over tick", v, 32'h0000_0500);
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr('h10, 32'd100);
      ticks(5);
      rd('h10, v);
      check("R3 five ticks", v, 32'd105);
      repeat (3) @(negedge clk);
      rd('h10, v);
      check("R3 holds without tick", v, 32'd105);
      wr('h10, 32'hFFFF_FFFE);
      ticks(3);
      rd('h10, v);
      check("R3 wrap", v, 32'h0000_0001);
   endtask

   task automatic t_match_regs();
      logic [31:0] v;
      for (int n = 0; n < 4; n++) wr(8'(n*4), 32'hA5A5_0000 + 32'(n * 32'h1111));
      for (int n = 0; n < 4; n++) begin
         rd(8'(n*4), v);
         check("R4 compare readback", v, 32'hA5A5_0000 + 32'(n * 32'h1111));
      end
   endtask

   task automatic t_match();
      logic [31:0] v;
      wr('h1C, 32'h3);
      wr('h00, 32'd50);
      wr('h04, 32'd300);
      wr('h08, 32'd7000);
      wr('h0C, 32'd7000);
      wr('h10, 32'd45);
      ticks(4);
      check("R5 no irq before match", {28'h0, irq_o}, 32'h0);
      ticks(1);
      check("R5 irq0 on match edge", {28'h0, irq_o}, 32'h1);
      rd('h14, v);
      check("R5 status bit0", v, 32'h1);
      wr('h10, 32'd300);
      @(negedge clk);
      check("R5 load onto compare is no match", {28'h0, irq_o}, 32'h1);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      wr('h1C, 32'h1);
      wr('h04, 32'd60);
      wr('h10, 32'd55);
      ticks(10);
      rd('h14, v);
      check("R6 disabled channel status kept", v, 32'h1);
      check("R6 disabled channel irq low", {28'h0, irq_o}, 32'h1);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr('h14, 32'h2);
      rd('h14, v);
      check("R7 zero-bit write keeps status", v, 32'h1);
      wr('h14, 32'h1);
      rd('h14, v);
      check("R7 one-bit write clears status", v, 32'h0);
      check("R7 irq falls", {28'h0, irq_o}, 32'h0);
   endtask

   task automatic t_wdog();
      logic [31:0] v;
      wr('h1C, 32'h0);
      wr('h0C, 32'd200);
      wr('h18, 32'h1);
      rd('h18, v);
      check("R8 arm readback", v, 32'h1);
      wr('h10, 32'd198);
      ticks(2);
      repeat (2) @(negedge clk);
      check("R8 one reset pulse", 32'(rst_pulses), 32'd1);
      rd('h18, v);
      check("R8 arm cleared", v, 32'h0);
      rd('h14, v);
      check("R8 status3 untouched", v, 32'h0);
      wr('h10, 32'd198);
      ticks(2);
      repeat (2) @(negedge clk);
      check("R9 no pulse when disarmed", 32'(rst_pulses), 32'd1);
   endtask

   task automatic t_ien();
      logic [31:0] v;
      wr('h1C, 32'hFFFF_FFFF);
      rd('h1C, v);
      check("R10 enable width", v, 32'h0000_0FFF);
      wr('h1C, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr('h10, 32'h0000_0777);
      rd('h20, v);
      check("R11 unmapped read", v, 32'h0);
      rd('h05, v);
      check("R11 unaligned read", v, 32'h0);
      wr('h24, 32'hFFFF_FFFF);
      wr('h11, 32'hFFFF_FFFF);
      rd('h10, v);
      check("R11 counter untouched", v, 32'h0000_0777);
      rd('h1C, v);
      check("R11 enable untouched", v, 32'h0);
      rd('h18, v);
      check("R11 arm untouched", v, 32'h0);
      rd('h00, v);
      check("R11 compare untouched", v, 32'd50);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_pass, n_total);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_count();
      t_match_regs();
      t_match();
      t_disabled();
      t_clear();
      t_wdog();
      t_ien();
      t_unmapped();
      report();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_total++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end
endmodule